// File: doc/BRIEF.md
# SMBus Target Register-Access Bridge

This block converts a sequence of SMBus target transactions into one internal register command. A bit-level front end, outside the block, reports a start condition, each received byte and a stop condition as one-cycle events, and asks for transmit bytes one at a time during a read phase. The bridge decodes a command byte at the head of each transaction and gathers the address and write-data bytes. A sequence may span several transactions, marked by begin and end flags. At the stop of the closing transaction the bridge checks what it gathered and issues a read dword, write byte, write word or write dword on a request/acknowledge register port.

While the internal access is outstanding the bridge asks the front end to stretch the clock. Completion is signalled only by that hold being released; there is no busy flag to poll. A later read phase returns a length byte, a status byte and the last dword read. Malformed sequences are dropped, and the reason is left in the status byte.

Top module: `smb_reg_bridge`

## Requirements
- R1: The first byte after a start is the command byte. Bit 7 opens a sequence, bit 6 closes it, bit 5 picks the space (0 memory-mapped, 1 configuration) and bit 4 requests a checksum. Bits 3:2 pick the internal operation (00 read dword, 01 write byte, 10 write word, 11 write dword); rq_write is 0 only for the read. Bits 1:0 give the transaction size (00 one byte, 01 two bytes, 10 a count byte then four bytes, 11 reserved).
- R2: The payload bytes of all transactions in a sequence are concatenated in arrival order: selector byte, address high, address middle, address low, then the write data, least significant byte first. The command is issued at the stop of a transaction whose command byte has bit 6 set. A one-transaction sequence sets both bit 7 and bit 6.
- R3: In a four-byte transaction the first byte after the command is a byte count that must equal 4. It is not part of the payload.
- R4: rq_addr is {address high, address middle, address low[7:2]}. rq_be marks the addressed lanes: all four for dword operations, one lane at offset low[1:0] for a byte, and lanes 1:0 or 3:2 chosen by low[1] for a word. rq_wdata carries the data in those lanes and zero elsewhere.
- R5: In memory-mapped mode rq_sel is the selector byte and rq_ext is 0. In configuration mode rq_sel is {3'b000, selector[4:0]}, and rq_ext is 1 exactly when those five bus bits are nonzero.
- R6: rq_valid and bus_hold rise in the cycle after the issuing stop and fall in the cycle after rq_ack. The request fields stay stable until then. Both are 0 after reset.
- R7: Read-phase bytes, counted from each start, are 5, then the status byte, then the captured dword least significant byte first, then 0xFF. The dword is captured from rq_rdata when a read command is acknowledged.
- R8: The checksum bit has no effect: no extra byte is expected on writes and none is added to a read phase.
- R9: A command byte with bit 7 set while a sequence is open discards the gathered payload and starts afresh.
- R10: A transaction whose command byte lacks bit 7 while no sequence is open is ignored, including one with bit 6 set: no command is issued and the status byte is unchanged.
- R11: Status codes: 0x01 for transaction size 11, reported at the command byte; 0x02 for a transaction length, byte count or sequence total that does not match; 0x03 for an address not aligned to the operation width. Any of these closes the sequence without a command.
- R12: The status byte becomes 0x00 when a command is issued, and at the stop of a transaction that requested read bytes unless that same stop records an error.
- R13: An acknowledge in the same cycle as the next start takes effect together with it: the read data is captured, the hold is released and the new transaction is parsed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start or repeated start seen |
| ev_stop | input | 1 | Stop seen |
| ev_byte_vld | input | 1 | A received byte is on ev_byte |
| ev_byte | input | 8 | Received byte |
| rd_byte_req | input | 1 | Front end consumes tx_byte |
| tx_byte | output | 8 | Next byte of the read phase |
| bus_hold | output | 1 | Clock-stretch request |
| rq_valid | output | 1 | Internal command pending |
| rq_write | output | 1 | Command is a write |
| rq_cfg | output | 1 | Configuration space selected |
| rq_ext | output | 1 | Register window beyond the standard configuration space |
| rq_sel | output | 8 | Region or bus selector |
| rq_addr | output | 22 | Dword address |
| rq_be | output | 4 | Byte-lane enables |
| rq_wdata | output | 32 | Write data, lane aligned |
| rq_ack | input | 1 | Internal access complete |
| rq_rdata | input | 32 | Read data, valid with rq_ack |

## Verification
Two events can land on the same edge: the completion acknowledge of an internal access and the start event of the next transaction. The bench turns off its automatic responder, waits for a pending read and then drives rq_ack and ev_start together. It then reads the return bytes in that same transaction. The hold must drop one cycle later and the returned dword must be the value given with that acknowledge. A reference model fed with the same events is compared against the outputs on every cycle.

// File: rtl/smb_reg_bridge.sv
module smb_reg_bridge #(
  parameter int PB_DEPTH = 8,
  parameter int CNT_W    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_start,
  input  logic        ev_stop,
  input  logic        ev_byte_vld,
  input  logic [7:0]  ev_byte,
  input  logic        rd_byte_req,
  output logic [7:0]  tx_byte,
  output logic        bus_hold,
  output logic        rq_valid,
  output logic        rq_write,
  output logic        rq_cfg,
  output logic        rq_ext,
  output logic [7:0]  rq_sel,
  output logic [21:0] rq_addr,
  output logic [3:0]  rq_be,
  output logic [31:0] rq_wdata,
  input  logic        rq_ack,
  input  logic [31:0] rq_rdata
);
  localparam logic [7:0] ST_OK    = 8'h00;
  localparam logic [7:0] ST_RSVD  = 8'h01;
  localparam logic [7:0] ST_LEN   = 8'h02;
  localparam logic [7:0] ST_ALIGN = 8'h03;
  localparam logic [7:0] RET_LEN  = 8'd5;
  localparam int PB_W = $clog2(PB_DEPTH + 1);
  localparam int IX_W = $clog2(PB_DEPTH);

  logic             cmd_seen, drop, cmd_end;
  logic [1:0]       cmd_bsz;
  logic             seq_open, seq_cfg;
  logic [1:0]       seq_isz;
  logic [CNT_W-1:0] tr_n, tr_need;
  logic [7:0]       cnt_b;
  logic [7:0]       pb [PB_DEPTH];
  logic [PB_W-1:0]  pb_n;
  logic             pb_ovf;
  logic [7:0]       status;
  logic [31:0]      rdat;
  logic [2:0]       rd_idx;
  logic             rd_seen;

  logic       pay_we, is_cnt, tr_ok, tot_ok, algn_ok, take, fin, set_err, issue;
  logic [2:0] dlen;
  logic [1:0] off;
  logic [3:0] be_n;
  logic [31:0] wd_n;
  logic [7:0] err_code;

  assign bus_hold = rq_valid;
  assign off      = pb[3][1:0];
  assign is_cnt   = cmd_bsz == 2'b10 && tr_n == '0;
  assign pay_we   = ev_byte_vld && cmd_seen && !drop && !is_cnt;

  always_comb begin
    case (cmd_bsz)
      2'b00:   tr_need = CNT_W'(1);
      2'b01:   tr_need = CNT_W'(2);
      default: tr_need = CNT_W'(5);
    endcase
    case (seq_isz)
      2'b00:   dlen = 3'd0;
      2'b01:   dlen = 3'd1;
      2'b10:   dlen = 3'd2;
      default: dlen = 3'd4;
    endcase
    case (seq_isz)
      2'b01:   algn_ok = 1'b1;
      2'b10:   algn_ok = !off[0];
      default: algn_ok = off == 2'b00;
    endcase
  end

  assign tr_ok    = tr_n == tr_need && (cmd_bsz != 2'b10 || cnt_b == 8'd4);
  assign tot_ok   = !pb_ovf && pb_n == PB_W'(4) + PB_W'(dlen);
  assign take     = ev_stop && cmd_seen && !drop;
  assign fin      = take && tr_ok && cmd_end;
  assign set_err  = take && (!tr_ok || (cmd_end && (!tot_ok || !algn_ok)));
  assign err_code = (!tr_ok || !tot_ok) ? ST_LEN : ST_ALIGN;
  assign issue    = fin && tot_ok && algn_ok && (!rq_valid || rq_ack);

  always_comb begin
    case (seq_isz)
      2'b00: begin
        be_n = 4'hF;
        wd_n = '0;
      end
      2'b01: begin
        be_n = 4'b0001 << off;
        wd_n = {24'h0, pb[4]} << {off, 3'b000};
      end
      2'b10: begin
        be_n = off[1] ? 4'b1100 : 4'b0011;
        wd_n = {16'h0, pb[5], pb[4]} << {off[1], 4'b0000};
      end
      default: begin
        be_n = 4'hF;
        wd_n = {pb[7], pb[6], pb[5], pb[4]};
      end
    endcase
  end

  always_comb begin
    case (rd_idx)
      3'd0:    tx_byte = RET_LEN;
      3'd1:    tx_byte = status;
      3'd2:    tx_byte = rdat[7:0];
      3'd3:    tx_byte = rdat[15:8];
      3'd4:    tx_byte = rdat[23:16];
      3'd5:    tx_byte = rdat[31:24];
      default: tx_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk)
    if (pay_we && pb_n < PB_W'(PB_DEPTH)) pb[pb_n[IX_W-1:0]] <= ev_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_seen <= 1'b0;
      drop     <= 1'b0;
      cmd_end  <= 1'b0;
      cmd_bsz  <= 2'b00;
      seq_open <= 1'b0;
      seq_cfg  <= 1'b0;
      seq_isz  <= 2'b00;
      tr_n     <= '0;
      cnt_b    <= 8'h00;
      pb_n     <= '0;
      pb_ovf   <= 1'b0;
      status   <= ST_OK;
      rdat     <= '0;
      rd_idx   <= 3'd0;
      rd_seen  <= 1'b0;
      rq_valid <= 1'b0;
      rq_write <= 1'b0;
      rq_cfg   <= 1'b0;
      rq_ext   <= 1'b0;
      rq_sel   <= 8'h00;
      rq_addr  <= '0;
      rq_be    <= 4'h0;
      rq_wdata <= '0;
    end else begin
      if (ev_start) begin
        cmd_seen <= 1'b0;
        rd_idx   <= 3'd0;
        rd_seen  <= 1'b0;
      end

      if (ev_byte_vld) begin
        if (!cmd_seen) begin
          cmd_seen <= 1'b1;
          cmd_end  <= ev_byte[6];
          cmd_bsz  <= ev_byte[1:0];
          tr_n     <= '0;
          cnt_b    <= 8'h00;
          if (ev_byte[1:0] == 2'b11) begin
            status   <= ST_RSVD;
            seq_open <= 1'b0;
            drop     <= 1'b1;
          end else if (ev_byte[7]) begin
            seq_open <= 1'b1;
            seq_cfg  <= ev_byte[5];
            seq_isz  <= ev_byte[3:2];
            pb_n     <= '0;
            pb_ovf   <= 1'b0;
            drop     <= 1'b0;
          end else begin
            drop <= !seq_open;
          end
        end else if (!drop) begin
          if (tr_n != '1) tr_n <= tr_n + 1'b1;
          if (is_cnt) cnt_b <= ev_byte;
          else if (pb_n < PB_W'(PB_DEPTH)) pb_n <= pb_n + 1'b1;
          else pb_ovf <= 1'b1;
        end
      end

      if (rd_byte_req) begin
        rd_seen <= 1'b1;
        if (rd_idx != 3'd6) rd_idx <= rd_idx + 3'd1;
      end

      if (rq_valid && rq_ack) begin
        rq_valid <= 1'b0;
        if (!rq_write) rdat <= rq_rdata;
      end

      if (ev_stop) begin
        cmd_seen <= 1'b0;
        if (take && (!tr_ok || cmd_end)) seq_open <= 1'b0;
        if (rd_seen) status <= ST_OK;
        if (set_err) status <= err_code;
        if (issue) begin
          rq_valid <= 1'b1;
          rq_write <= seq_isz != 2'b00;
          rq_cfg   <= seq_cfg;
          rq_sel   <= seq_cfg ? {3'b000, pb[0][4:0]} : pb[0];
          rq_ext   <= seq_cfg && pb[0][4:0] != 5'd0;
          rq_addr  <= {pb[1], pb[2], pb[3][7:2]};
          rq_be    <= be_n;
          rq_wdata <= wd_n;
          status   <= ST_OK;
        end
      end
    end
  end
endmodule

module smb_reg_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_stop,
  input logic        bus_hold,
  input logic        rq_valid,
  input logic        rq_ack,
  input logic        rq_write,
  input logic        rq_cfg,
  input logic        rq_ext,
  input logic [7:0]  rq_sel,
  input logic [21:0] rq_addr,
  input logic [3:0]  rq_be,
  input logic [31:0] rq_wdata
);
  a_r6_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ack |=> rq_valid && $stable(rq_addr) && $stable(rq_be) && $stable(rq_wdata));

  a_r6_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_hold) |-> $past(rq_ack));

  a_r6_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_ack && !ev_stop |=> !rq_valid);

  a_r2_issue_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rq_valid) |-> $past(ev_stop));

  a_r4_read_full: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_write |-> rq_be == 4'hF);

  a_r4_lane_shape: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> ($countones(rq_be) == 1 || rq_be == 4'h3 || rq_be == 4'hC || rq_be == 4'hF));

  a_r5_mem_no_ext: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_cfg |-> !rq_ext);

  a_r5_cfg_bus_width: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_cfg |-> rq_sel[7:5] == 3'b000);
endmodule

bind smb_reg_bridge smb_reg_bridge_chk u_chk (.*);

// File: tb/tb_smb_reg_bridge.sv
module tb_smb_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_start, ev_stop, ev_byte_vld, rd_byte_req, rq_ack;
  logic [7:0]  ev_byte;
  logic [31:0] rq_rdata;
  logic [7:0]  tx_byte, rq_sel;
  logic        bus_hold, rq_valid, rq_write, rq_cfg, rq_ext;
  logic [21:0] rq_addr;
  logic [3:0]  rq_be;
  logic [31:0] rq_wdata;

  always #2.5 clk = ~clk;

  smb_reg_bridge dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  bit auto_ack = 1;
  int dly = 3;
  logic [7:0] bq[$];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // reference model
  logic        m_valid, m_wr, m_cfg, m_ext;
  logic [7:0]  m_sel, m_status;
  logic [21:0] m_addr;
  logic [3:0]  m_be;
  logic [31:0] m_wd, m_rdat;
  int          m_rdidx, m_trn;
  bit          m_rdseen, m_cmdseen, m_drop, m_open, m_mode;
  logic [1:0]  m_isz;
  logic [7:0]  m_cmd, m_cnt;
  logic [7:0]  q[$];

  function automatic logic [7:0] exp_tx(input int idx);
    if (idx == 0) return 8'd5;
    if (idx == 1) return m_status;
    if (idx < 6) return m_rdat[8*(idx-2) +: 8];
    return 8'hFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_wr = 0; m_cfg = 0; m_ext = 0; m_sel = 0; m_status = 0;
      m_addr = 0; m_be = 0; m_wd = 0; m_rdat = 0; m_rdidx = 0; m_trn = 0;
      m_rdseen = 0; m_cmdseen = 0; m_drop = 0; m_open = 0; m_mode = 0;
      m_isz = 0; m_cmd = 0; m_cnt = 0; q.delete();
    end else begin
      if (ev_start) begin m_cmdseen = 0; m_rdidx = 0; m_rdseen = 0; end
      if (ev_byte_vld) begin
        if (!m_cmdseen) begin
          m_cmdseen = 1; m_cmd = ev_byte; m_trn = 0; m_cnt = 0;
          if (ev_byte[1:0] == 2'b11) begin m_status = 8'h01; m_open = 0; m_drop = 1; end
          else if (ev_byte[7]) begin
            m_open = 1; q.delete(); m_mode = ev_byte[5]; m_isz = ev_byte[3:2]; m_drop = 0;
          end else m_drop = !m_open;
        end else if (!m_drop) begin
          if (m_cmd[1:0] == 2'b10 && m_trn == 0) m_cnt = ev_byte;
          else q.push_back(ev_byte);
          m_trn++;
        end
      end
      if (rd_byte_req) begin m_rdseen = 1; if (m_rdidx < 6) m_rdidx++; end
      if (rq_ack && m_valid) begin m_valid = 0; if (!m_wr) m_rdat = rq_rdata; end
      if (ev_stop) begin
        int need, dl, off, err;
        bit go;
        err = 0; go = 0;
        if (m_cmdseen && !m_drop) begin
          need = (m_cmd[1:0] == 2'b00) ? 1 : (m_cmd[1:0] == 2'b01) ? 2 : 5;
          if (m_trn != need || (m_cmd[1:0] == 2'b10 && m_cnt != 4)) err = 2;
          else if (m_cmd[6]) begin
            dl = (m_isz == 0) ? 0 : (m_isz == 3) ? 4 : int'(m_isz);
            if (q.size() != 4 + dl) err = 2;
            else begin
              off = int'(q[3]) % 4;
              if ((m_isz == 2 && off % 2 != 0) || ((m_isz == 0 || m_isz == 3) && off != 0)) err = 3;
              else go = 1;
            end
          end
          if (err != 0 || m_cmd[6]) m_open = 0;
        end
        if (m_rdseen) m_status = 0;
        if (err != 0) m_status = 8'(err);
        if (go && !m_valid) begin
          m_valid = 1; m_wr = m_isz != 0; m_cfg = m_mode;
          m_ext = m_mode && (q[0] % 32 != 0);
          m_sel = m_mode ? 8'(q[0] % 32) : q[0];
          m_addr = 22'((int'(q[1]) * 65536 + int'(q[2]) * 256 + int'(q[3])) / 4);
          m_be = 0; m_wd = 0;
          dl = (m_isz == 0) ? 4 : (m_isz == 3) ? 4 : int'(m_isz);
          off = (dl == 4) ? 0 : (int'(q[3]) % 4);
          for (int i = 0; i < dl; i++) begin
            m_be[off + i] = 1'b1;
            if (m_wr) m_wd[8*(off+i) +: 8] = q[4+i];
          end
          m_status = 0;
        end
        m_cmdseen = 0;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) if (rst_n) begin
    chk("R6 bus_hold", bus_hold, m_valid);
    chk("R6 rq_valid", rq_valid, m_valid);
    if (m_valid) begin
      chk("R1 rq_write", rq_write, m_wr);
      chk("R5 rq_cfg", rq_cfg, m_cfg);
      chk("R5 rq_sel", rq_sel, m_sel);
      chk("R5 rq_ext", rq_ext, m_ext);
      chk("R4 rq_addr", rq_addr, m_addr);
      chk("R4 rq_be", rq_be, m_be);
      chk("R4 rq_wdata", rq_wdata, m_wd);
    end
  end

  // register-port responder
  always @(negedge clk) if (auto_ack) begin
    if (rq_ack) rq_ack = 1'b0;
    else if (rq_valid) begin
      if (dly == 0) begin
        rq_ack = 1'b1;
        rq_rdata = {rq_addr[15:0], rq_sel, 8'h5A};
        dly = 3;
      end else dly--;
    end
  end

  task automatic send_tr();
    @(negedge clk) ev_start = 1;
    @(negedge clk) ev_start = 0;
    foreach (bq[i]) begin
      @(negedge clk) begin ev_byte_vld = 1; ev_byte = bq[i]; end
    end
    @(negedge clk) begin ev_byte_vld = 0; ev_stop = 1; end
    @(negedge clk) ev_stop = 0;
  endtask

  task automatic expect_issue(input string tag, input logic wr, input logic [7:0] sel,
                              input logic ext, input logic [21:0] addr,
                              input logic [3:0] be, input logic [31:0] wd);
    int t = 0;
    while (!rq_valid && t < 20) begin @(negedge clk); t++; end
    chk({tag, " issued"}, rq_valid, 1);
    chk("R1 write flag", rq_write, wr);
    chk({tag, " sel"}, rq_sel, sel);
    chk({tag, " ext"}, rq_ext, ext);
    chk({tag, " addr"}, rq_addr, addr);
    chk({tag, " be"}, rq_be, be);
    chk({tag, " wdata"}, rq_wdata, wd);
    t = 0;
    while (bus_hold && t < 40) begin @(negedge clk); t++; end
  endtask

  task automatic expect_none(input string tag);
    repeat (6) begin @(negedge clk); chk(tag, rq_valid, 0); end
  endtask

  task automatic read_ret(input string tag, input logic [7:0] exp_st);
    @(negedge clk) ev_start = 1;
    @(negedge clk) ev_start = 0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk) rd_byte_req = 1;
      chk("R7 tx_byte", tx_byte, exp_tx(m_rdidx));
      if (i == 1) chk(tag, tx_byte, exp_st);
      if (i == 6) chk("R7 past end", tx_byte, 8'hFF);
    end
    @(negedge clk) begin rd_byte_req = 0; ev_stop = 1; end
    @(negedge clk) ev_stop = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ev_start = 0; ev_stop = 0; ev_byte_vld = 0; ev_byte = 0;
    rd_byte_req = 0; rq_ack = 0; rq_rdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R6 reset valid", rq_valid, 0);
    chk("R6 reset hold", bus_hold, 0);
    chk("R7 reset length byte", tx_byte, 8'd5);

    // single-transaction read dword, memory-mapped
    bq = '{8'hC2, 8'h04, 8'h07, 8'h12, 8'h34, 8'h58};
    send_tr();
    expect_issue("R2 single", 0, 8'h07, 0, 22'h48D16, 4'hF, 32'h0);
    read_ret("R7 status ok", 8'h00);

    // two-transaction write dword, configuration mode, bus 3
    bq = '{8'hAE, 8'h04, 8'h03, 8'h00, 8'h01, 8'h40};
    send_tr();
    bq = '{8'h6E, 8'h04, 8'h11, 8'h22, 8'h33, 8'h44};
    send_tr();
    expect_issue("R3 count excluded", 1, 8'h03, 1, 22'h00050, 4'hF, 32'h44332211);

    // write word over three two-byte transactions
    bq = '{8'h89, 8'h05, 8'h00}; send_tr();
    bq = '{8'h09, 8'h10, 8'h22}; send_tr();
    bq = '{8'h49, 8'hAA, 8'hBB}; send_tr();
    expect_issue("R2 split order", 1, 8'h05, 0, 22'h00408, 4'hC, 32'hBBAA0000);

    // write byte, configuration bus 0, checksum bit set
    bq = '{8'hB4, 8'h00}; send_tr();
    bq = '{8'h34, 8'h00}; send_tr();
    bq = '{8'h34, 8'h02}; send_tr();
    bq = '{8'h34, 8'h03}; send_tr();
    bq = '{8'h74, 8'h9C}; send_tr();
    expect_issue("R8 pec ignored", 1, 8'h00, 0, 22'h00080, 4'h8, 32'h9C000000);
    read_ret("R8 no extra byte", 8'h00);

    // begin while open
    bq = '{8'h89, 8'h05, 8'h00}; send_tr();
    bq = '{8'hE2, 8'h04, 8'h1F, 8'h00, 8'h00, 8'h04}; send_tr();
    expect_issue("R9 restart", 0, 8'h1F, 1, 22'h00001, 4'hF, 32'h0);
    read_ret("R12 status after issue", 8'h00);

    // end without open sequence
    bq = '{8'h4A, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00}; send_tr();
    expect_none("R10 no command");
    read_ret("R10 status unchanged", 8'h00);

    // reserved size
    bq = '{8'hC3, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00}; send_tr();
    expect_none("R11 reserved no command");
    read_ret("R11 reserved code", 8'h01);
    read_ret("R12 cleared after read", 8'h00);

    // transaction length short
    bq = '{8'hC2, 8'h04, 8'h00, 8'h00, 8'h00}; send_tr();
    expect_none("R11 short no command");
    read_ret("R11 length code", 8'h02);

    // wrong byte count
    bq = '{8'hC2, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00}; send_tr();
    expect_none("R3 bad count no command");
    read_ret("R3 bad count code", 8'h02);

    // sequence total too short for write word
    bq = '{8'hCA, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00}; send_tr();
    expect_none("R11 total no command");
    read_ret("R11 total code", 8'h02);

    // abort closes the open sequence
    bq = '{8'h8E, 8'h04, 8'h01, 8'h00, 8'h00, 8'h00}; send_tr();
    bq = '{8'h6F, 8'h00}; send_tr();
    bq = '{8'h6E, 8'h04, 8'h01, 8'h02, 8'h03, 8'h04}; send_tr();
    expect_none("R11 closed after abort");
    read_ret("R11 abort code kept", 8'h01);

    // misaligned read dword
    bq = '{8'hC2, 8'h04, 8'h00, 8'h00, 8'h00, 8'h02}; send_tr();
    expect_none("R11 misaligned no command");
    read_ret("R11 align code", 8'h03);

    // acknowledge coincident with next start
    bq = '{8'hC2, 8'h04, 8'h02, 8'h00, 8'h00, 8'h10}; send_tr();
    while (!rq_valid) @(negedge clk);
    auto_ack = 0;
    @(negedge clk) begin rq_ack = 1; rq_rdata = 32'hDEADBEEF; ev_start = 1; end
    @(negedge clk) begin rq_ack = 0; ev_start = 0; end
    chk("R13 hold released", bus_hold, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) rd_byte_req = 1;
      chk("R7 tx_byte", tx_byte, exp_tx(m_rdidx));
      if (i == 2) chk("R13 captured data", tx_byte, 8'hEF);
      if (i == 5) chk("R13 captured top", tx_byte, 8'hDE);
    end
    @(negedge clk) begin rd_byte_req = 0; ev_stop = 1; end
    @(negedge clk) ev_stop = 0;
    auto_ack = 1;

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule